// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial bus in front of a byte-wide memory array. It oversamples the bus clock and data lines in the system clock domain and detects start and stop conditions. It accepts a device select byte whose fixed type code and three strap bits must match before it answers. It then runs write, random read, current-address read and sequential read transfers against a synchronous RAM model. SDA is never driven high. The block only pulls the line low through an output enable, and the board pull-up supplies the high level.

Writes are gathered in a page buffer and committed only after the stop condition. The commit happens inside a timed internal write cycle. While that cycle runs, the device refuses its own address, so a bus master can poll until the write is finished. A write-protect input freezes the whole array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A start condition (SDA falling while SCL is high) restarts byte reception at any point. A stop condition (SDA rising while SCL is high) ends the transfer and releases SDA. A write cut off by a stop before any complete data byte commits nothing and starts no write cycle.
- R2: The device select byte is, MSB first, type code 1010, then the strap bits strap_i[2:0], then R/W (0 = write, 1 = read). Only a matching byte is acknowledged. A mismatch gets a NACK, and every bit that follows is ignored (SDA stays released) until the next start.
- R3: A write select is followed by a high and a low word-address byte. Only the low ADDR_W bits (12 by default) of that 16-bit value are used and the upper bits are ignored. Every address and data byte is acknowledged.
- R4: Up to PAGE_BYTES (32) data bytes are stored in a page buffer at the pointer's low 5 bits, which wrap within the current page, so byte 33 of a transfer overwrites byte 1. Only loaded locations of that page are written, and the write happens after the stop.
- R5: The internal write cycle lasts WRITE_CYCLES clocks after the stop. During it, the device select byte is NACKed. After it ends, the select byte is ACKed and the new data reads back.
- R6: With wp_i high at the stop, data bytes are still ACKed, but the array is not modified and no write cycle starts, so the next select byte is ACKed at once.
- R7: On a read select, the byte at the pointer is shifted out MSB first and the pointer advances after each byte. A master ACK requests the next byte. A master NACK ends the read and SDA is released.
- R8: A current-address read returns the byte at the pointer left by the previous transfer. That is one past the last byte read, or the next in-page location after the last byte written.
- R9: During a sequential read, the pointer wraps from the last array address to address 0.
- R10: SDA is only pulled low through sda_oe_o, which is 0 during and after reset and in idle. sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND level) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Board strap bits that complete the device select code |
| wp_i | input | 1 | 1 blocks every array write |

## Verification
Two functions can fall into the same window: the end of the internal write cycle and a master polling with a device select byte. The bench issues a poll straight after the stop of a page write. That poll must be refused. It then keeps polling, and on the first ACK it reads the whole page back and compares it against values it has worked out from the wrap rule. A second collision, a stop that arrives while write-protect is high, is judged by an immediate ACK on the next poll and by the array being unchanged.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_READ
  } slv_state_e;
endpackage

// File: rtl/i2c_bus_sense.sv
module i2c_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_q      <= scl_o;
      sda_q      <= sda_o;
    end
  end

  assign scl_o      = scl_sync_q[SYNC_STAGES-1];
  assign sda_o      = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 375000,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int PAGE_W      = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [OFF_W-1:0]  load_off_i,
  input  logic [7:0]        load_data_i,
  input  logic              go_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              has_data_o,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o
);
  localparam int CNT_W = $clog2(WRITE_CYCLES) + 1;
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYCLES - 1);

  logic [7:0]            page_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [PAGE_W-1:0]     page_hold_q;
  logic                  busy_q;
  logic [OFF_W-1:0]      slot;

  assign slot = cnt_q[OFF_W-1:0];

  always_ff @(posedge clk_i) begin
    if (load_i) page_q[load_off_i] <= load_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q       <= '0;
      cnt_q       <= '0;
      page_hold_q <= '0;
      busy_q      <= 1'b0;
    end else begin
      if (clear_i) vld_q <= '0;
      else if (load_i) vld_q[load_off_i] <= 1'b1;
      if (go_i) begin
        busy_q      <= 1'b1;
        cnt_q       <= '0;
        page_hold_q <= page_i;
      end else if (busy_q) begin
        if (cnt_q == LAST_CNT) begin
          busy_q <= 1'b0;
          vld_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  // one buffered byte per clock in the first PAGE_BYTES cycles of the write cycle
  assign we_o       = busy_q && (cnt_q < PAGE_CNT) && vld_q[slot];
  assign waddr_o    = {page_hold_q, slot};
  assign wdata_o    = page_q[slot];
  assign busy_o     = busy_q;
  assign has_data_o = |vld_q;
endmodule

// File: rtl/eeprom_sram.sv
module eeprom_sram #(
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 375000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic pc_busy, pc_has, pc_we, pc_load, pc_clear, pc_go;
  logic [ADDR_W-1:0] pc_waddr;
  logic [7:0] pc_wdata, rd_data;

  slv_state_e        state_q;
  logic [3:0]        bit_cnt_q;
  logic              ack_ph_q, sda_oe_q;
  logic [7:0]        rx_q, tx_q;
  logic [ADDR_W-9:0] ahi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rx_done, dev_hit, dev_eval, mem_we;

  i2c_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) i_sense (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  eeprom_page_commit #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
  ) i_commit (
    .clk_i, .rst_ni,
    .clear_i(pc_clear), .load_i(pc_load), .load_off_i(ptr_q[OFF_W-1:0]),
    .load_data_i(rx_q), .go_i(pc_go), .page_i(ptr_q[ADDR_W-1:OFF_W]),
    .has_data_o(pc_has), .busy_o(pc_busy), .we_o(pc_we),
    .waddr_o(pc_waddr), .wdata_o(pc_wdata)
  );

  assign mem_we = pc_we & ~wp_i;

  eeprom_sram #(.ADDR_W(ADDR_W)) i_sram (
    .clk_i, .we_i(mem_we), .waddr_i(pc_waddr), .wdata_i(pc_wdata),
    .raddr_i(ptr_q), .rdata_o(rd_data)
  );

  assign rx_done  = scl_fall && !ack_ph_q && (bit_cnt_q == 4'd8);
  assign dev_hit  = (rx_q[7:4] == DEV_TYPE) && (rx_q[3:1] == strap_i) && !pc_busy;
  assign dev_eval = (state_q == ST_DEV) && rx_done;
  assign pc_load  = (state_q == ST_WDATA) && rx_done;
  assign pc_clear = (state_q == ST_ALO) && rx_done;
  assign pc_go    = stop_c && (state_q == ST_WDATA) && pc_has && !wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
      rx_q      <= '0;
      tx_q      <= '0;
      ahi_q     <= '0;
      ptr_q     <= '0;
    end else if (start_c) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      ack_ph_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else if (stop_c) begin
      state_q  <= ST_IDLE;
      ack_ph_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: ;
        ST_READ: begin
          if (ack_ph_q || bit_cnt_q == 4'd9) begin
            if (scl_fall) begin
              ack_ph_q  <= 1'b0;
              tx_q      <= rd_data;
              sda_oe_q  <= ~rd_data[7];
              ptr_q     <= ptr_q + ADDR_W'(1);
              bit_cnt_q <= '0;
            end
          end else if (scl_rise) begin
            if (bit_cnt_q == 4'd8) begin
              if (sda_s) state_q <= ST_IDLE;  // master NACK ends the read
              else bit_cnt_q <= 4'd9;
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end else if (scl_fall) begin
            if (bit_cnt_q < 4'd8) begin
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_q <= ~tx_q[6];
            end else begin
              sda_oe_q <= 1'b0;
            end
          end
        end
        default: begin
          if (ack_ph_q) begin
            if (scl_fall) begin
              ack_ph_q  <= 1'b0;
              sda_oe_q  <= 1'b0;
              bit_cnt_q <= '0;
            end
          end else if (scl_rise && bit_cnt_q < 4'd8) begin
            rx_q      <= {rx_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (rx_done) begin
            ack_ph_q <= 1'b1;
            sda_oe_q <= 1'b1;
            case (state_q)
              ST_DEV: begin
                if (dev_hit) begin
                  state_q <= rx_q[0] ? ST_READ : ST_AHI;
                end else begin
                  state_q  <= ST_IDLE;
                  ack_ph_q <= 1'b0;
                  sda_oe_q <= 1'b0;
                end
              end
              ST_AHI: begin
                ahi_q   <= rx_q[ADDR_W-9:0];
                state_q <= ST_ALO;
              end
              ST_ALO: begin
                ptr_q   <= {ahi_q, rx_q};
                state_q <= ST_WDATA;
              end
              default: ptr_q <= {ptr_q[ADDR_W-1:OFF_W], ptr_q[OFF_W-1:0] + OFF_W'(1)};
            endcase
          end
        end
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
endmodule

// File: rtl/i2c_eeprom_checker.sv
module i2c_eeprom_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s_i,
  input logic sda_oe_i,
  input logic idle_i,
  input logic dev_eval_i,
  input logic dev_hit_i,
  input logic busy_i,
  input logic stop_i,
  input logic wp_i
);
  a_r10_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_oe_i);

  a_r10_change_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s_i && $past(scl_s_i)) |-> $stable(sda_oe_i));

  a_r2_miss_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_eval_i && !dev_hit_i) |=> !sda_oe_i);

  a_r5_busy_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_eval_i && busy_i) |=> !sda_oe_i);

  a_r6_wp_no_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_i) |=> !busy_i);
endmodule

bind i2c_eeprom_slave i2c_eeprom_checker i_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .scl_s_i(scl_s),
  .sda_oe_i(sda_oe_q),
  .idle_i(state_q == eeprom_pkg::ST_IDLE),
  .dev_eval_i(dev_eval),
  .dev_hit_i(dev_hit),
  .busy_i(pc_busy),
  .stop_i(stop_c),
  .wp_i(wp_i)
);

// File: tb/test_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module test_i2c_eeprom_slave;
  localparam int Q  = 10;
  localparam int WC = 2000;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = STRAP;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;
  int n_chk = 0, n_bad = 0;
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  always #4 clk = ~clk;

  i2c_eeprom_slave #(.WRITE_CYCLES(WC)) i_i2c_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rw);
    return {4'b1010, s, rw};
  endfunction

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b; tq();
    m_scl = 1'b1; tq();
    s = sda_line; tq();
    m_scl = 1'b0; tq();
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tq();
    m_scl = 1'b1; tq();
    m_sda = 1'b0; tq();
    m_scl = 1'b0; tq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tq();
    m_scl = 1'b1; tq();
    m_sda = 1'b1; tq();
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = (s == 1'b0);
  endtask

  task automatic rx_byte(input logic more, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, s);
      b = {b[6:0], s};
    end
    bit_io(~more, s);
  endtask

  task automatic wr_txn(input logic [15:0] a, input int n, input string req);
    logic ack;
    bus_start();
    tx_byte(dev(STRAP, 1'b0), ack); chk({req, " write select ack"}, ack, 1);
    tx_byte(a[15:8], ack);          chk({req, " addr hi ack"}, ack, 1);
    tx_byte(a[7:0], ack);           chk({req, " addr lo ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      tx_byte(wbuf[k], ack);        chk({req, " data ack"}, ack, 1);
    end
    bus_stop();
  endtask

  task automatic poll(output logic ack);
    bus_start();
    tx_byte(dev(STRAP, 1'b0), ack);
    bus_stop();
  endtask

  task automatic wait_ready(input string req);
    logic ack;
    int polls = 0;
    do begin
      poll(ack);
      polls++;
    end while (!ack && polls < 40);
    chk({req, " device answers after write cycle"}, ack, 1);
  endtask

  task automatic rd_txn(input logic [15:0] a, input int n, input string req);
    logic ack;
    bus_start();
    tx_byte(dev(STRAP, 1'b0), ack); chk({req, " select ack"}, ack, 1);
    tx_byte(a[15:8], ack);          chk({req, " addr hi ack"}, ack, 1);
    tx_byte(a[7:0], ack);           chk({req, " addr lo ack"}, ack, 1);
    bus_start();
    tx_byte(dev(STRAP, 1'b1), ack); chk({req, " read select ack"}, ack, 1);
    for (int k = 0; k < n; k++) rx_byte(k < n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic cur_rd(input int n, input string req);
    logic ack;
    bus_start();
    tx_byte(dev(STRAP, 1'b1), ack); chk({req, " current read select ack"}, ack, 1);
    for (int k = 0; k < n; k++) rx_byte(k < n - 1, rbuf[k]);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R10 sda released after reset", sda_oe, 0);
  endtask

  task automatic t_basic();
    logic ack;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_txn(16'hF123, 4, "R3");
    poll(ack);
    chk("R5 select NACKed while write cycle busy", ack, 0);
    wait_ready("R5");
    rd_txn(16'h0123, 2, "R7");
    chk("R3 upper address bits ignored, byte 0", rbuf[0], 8'h11);
    chk("R7 sequential read second byte", rbuf[1], 8'h22);
    chk("R7 sda released after master NACK and stop", sda_oe, 0);
    cur_rd(1, "R8");
    chk("R8 current read continues after last read", rbuf[0], 8'h33);
  endtask

  task automatic t_nomatch();
    logic ack;
    bus_start();
    tx_byte(dev(3'b010, 1'b0), ack);
    chk("R2 wrong strap bits NACKed", ack, 0);
    tx_byte(8'h00, ack);
    chk("R2 bytes after mismatch ignored", ack, 0);
    bus_stop();
    bus_start();
    tx_byte({4'b1011, STRAP, 1'b1}, ack);
    chk("R2 wrong type code NACKed", ack, 0);
    bus_stop();
  endtask

  task automatic t_page();
    wbuf[0] = 8'h77;
    wr_txn(16'h0300, 1, "R4");
    wait_ready("R4");
    for (int k = 0; k < 34; k++) wbuf[k] = 8'h40 + 8'(k);
    wr_txn(16'h02FE, 34, "R4");
    wait_ready("R5");
    cur_rd(1, "R8");
    chk("R8 pointer after page write wrapped to page start", rbuf[0], 8'h42);
    rd_txn(16'h02E0, 33, "R4");
    for (int o = 0; o < 32; o++) begin
      logic [7:0] e;
      e = (o >= 30) ? 8'h40 + 8'(o + 2) : 8'h40 + 8'(o + 2);
      chk($sformatf("R4 page offset %0d after wrap", o), rbuf[o], e);
    end
    chk("R4 next page untouched", rbuf[32], 8'h77);
  endtask

  task automatic t_wp();
    logic ack;
    wbuf[0] = 8'h3C;
    wr_txn(16'h0010, 1, "R6");
    wait_ready("R6");
    wp = 1'b1;
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    wr_txn(16'h0010, 2, "R6");
    poll(ack);
    chk("R6 no write cycle under protect", ack, 1);
    rd_txn(16'h0010, 1, "R6");
    chk("R6 array unchanged under protect", rbuf[0], 8'h3C);
    wp = 1'b0;
  endtask

  task automatic t_abort();
    logic ack, s;
    bus_start();
    tx_byte(dev(STRAP, 1'b0), ack); chk("R1 select ack", ack, 1);
    tx_byte(8'h00, ack);            chk("R1 addr hi ack", ack, 1);
    tx_byte(8'h10, ack);            chk("R1 addr lo ack", ack, 1);
    for (int i = 0; i < 4; i++) bit_io(1'b0, s);
    bus_stop();
    chk("R1 sda released after stop", sda_oe, 0);
    poll(ack);
    chk("R1 partial byte starts no write cycle", ack, 1);
    rd_txn(16'h0010, 1, "R1");
    chk("R1 partial byte not committed", rbuf[0], 8'h3C);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hA5;
    wr_txn(16'h0FFF, 1, "R9");
    wait_ready("R9");
    wbuf[0] = 8'h5A;
    wr_txn(16'h0000, 1, "R9");
    wait_ready("R9");
    rd_txn(16'h0FFF, 2, "R9");
    chk("R9 last array byte", rbuf[0], 8'hA5);
    chk("R9 pointer wrapped to address 0", rbuf[1], 8'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_nomatch();
    t_page();
    t_wp();
    t_abort();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule